// File: doc/BRIEF.md
# DDR Octal Memory Bus Master

This block is the host end of a byte-wide, double-data-rate memory bus. The bus has an active-low chip select, a true and a complement bus clock, an eight-bit data path split into separate output, output-enable and input wires, and a data strobe returned by the memory on reads. A request port with a valid/ready handshake takes one transaction at a time. Each request gives the direction, the address space, the burst type, a 32-bit word address, one write word and a read word count. The block runs from a system clock at twice the bus clock rate. Each system clock cycle of an active transaction carries exactly one bus clock edge.

A transaction opens with a 48-bit command/address phase of six bytes. An idle period of a configurable number of bus clocks follows, with the data path released. Then 16-bit words move. A write sends one word and stops. A read keeps clocking until the requested number of words has arrived, or until the host asks to stop at a word boundary. Read bytes are taken on transitions of the memory's strobe. Each assembled word is presented with a one-cycle valid flag, and a done pulse closes every transaction.

Top module: `octddr_master`

## Requirements
- R1: Chip select falls only while the bus clock is low. While chip select is high, the bus clock stays low.
- R2: The command/address phase is six bytes on the first six bus clock edges, starting with a rising edge. Bits 47..40 go first and bits 7..0 go last, with the output enable high on all six.
- R3: Command/address encoding: bit 47 is 1 for read, bit 46 is 1 for register space, bit 45 is 1 for linear burst, bits 44..16 are address bits 31..3, bits 15..3 are zero, and bits 2..0 are address bits 2..0.
- R4: Between the command/address phase and the data, exactly 2*cfg_latency bus clock edges pass with the output enable low. A latency of zero is allowed.
- R5: A write sends exactly one word: bits 15..8 on a rising edge, then bits 7..0 on the next falling edge. The burst type and the read word count have no effect on a write.
- R6: A read clocks out 2*(req_words_m1+1) data edges. An upper byte is taken when the strobe rises and a lower byte when it falls. Each finished word appears on rd_data with rd_valid high for one cycle.
- R7: If rd_cut is high at the end of a read word and more words remain, the transaction ends after that word.
- R8: Chip select rises while the bus clock is low. done pulses for one cycle, in the cycle in which chip select is high again.
- R9: req_ready is high only when no transaction is in progress. The request fields are captured when req_valid and req_ready are both high, and later changes have no effect on that transaction.
- R10: After reset: chip select high, bus clock low, complement clock high, output enable low, req_ready high, done and rd_valid low.
- R11: bus_ck_n is always the complement of bus_ck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_latency | input | LAT_W | Idle bus clocks between command/address and data |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_read | input | 1 | 1 = read, 0 = write |
| req_reg | input | 1 | 1 = register space |
| req_linear | input | 1 | 1 = linear burst, 0 = wrapped |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| req_words_m1 | input | LEN_W | Read word count minus one |
| rd_cut | input | 1 | Stop a read at the next word boundary |
| rd_valid | output | 1 | rd_data holds a new read word |
| rd_data | output | 16 | Assembled read word |
| done | output | 1 | Transaction finished |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ck | output | 1 | Bus clock |
| bus_ck_n | output | 1 | Complement bus clock |
| bus_dq_o | output | 8 | Data/command byte out |
| bus_dq_oe | output | 1 | Output enable for bus_dq_o |
| bus_dq_i | input | 8 | Data byte from memory |
| bus_strobe | input | 1 | Read data strobe from memory |

## Verification
A bus-side model in the bench records every byte on every clock edge. For reads, it returns words computed from the address, with the strobe edge-aligned to them. The sweep covers every latency from 0 to 3 crossed with read lengths of one to four words. That separates off-by-one errors in the idle count from errors in the data edge count. Writes are swept across latencies with both burst types and a non-zero read count, which shows that neither changes the single-word write. Reads with rd_cut raised tell early termination apart from a full burst. Request fields are overwritten right after acceptance, so the bench can see whether they were latched at the handshake.

// File: rtl/octddr_pkg.sv
package octddr_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_CA, ST_LAT, ST_DATA} seq_state_t;

   localparam int CA_W = 48;
   localparam int WORD_W = 16;

   function automatic logic [CA_W-1:0] pack_ca(input logic rd, input logic rg,
                                               input logic lin, input logic [31:0] a);
      return {rd, rg, lin, a[31:3], 13'd0, a[2:0]};
   endfunction
endpackage

// File: rtl/octddr_ck_gen.sv
module octddr_ck_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic ck,
   output logic ck_n
);
   // Edges are placed half a system cycle after data changes, centring them.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck   <= 1'b0;
         ck_n <= 1'b1;
      end else if (run) begin
         ck   <= ~ck;
         ck_n <= ~ck_n;
      end
   end

   assert_ck_rests_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> !ck);
   assert_ck_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ck_n == !ck);
endmodule

// File: rtl/octddr_tx_shift.sv
module octddr_tx_shift #(
   parameter int DQ_W = 8,
   parameter int SH_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SH_W-1:0] load_val,
   input  logic            shift,
   output logic [DQ_W-1:0] byte_o
);
   logic [SH_W-1:0] sh;

   generate
      if (SH_W % DQ_W != 0) begin : g_bad_w
         $error("SH_W must be a multiple of DQ_W");
      end
      if (SH_W == DQ_W) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sh <= '0;
            else if (load) sh <= load_val;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh <= '0;
            else if (load)  sh <= load_val;
            else if (shift) sh <= {sh[SH_W-DQ_W-1:0], {DQ_W{1'b0}}};
         end
      end
   endgenerate

   assign byte_o = sh[SH_W-1 -: DQ_W];
endmodule

// File: rtl/octddr_rd_cap.sv
module octddr_rd_cap #(
   parameter int DQ_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              strobe,
   input  logic [DQ_W-1:0]   dq_i,
   output logic              word_valid,
   output logic [2*DQ_W-1:0] word_o
);
   logic            strobe_p;
   logic [DQ_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_p   <= 1'b0;
         hi_q       <= '0;
         word_valid <= 1'b0;
         word_o     <= '0;
      end else begin
         strobe_p   <= strobe;
         word_valid <= 1'b0;
         if (arm && strobe && !strobe_p) hi_q <= dq_i;
         if (arm && !strobe && strobe_p) begin
            word_o     <= {hi_q, dq_i};
            word_valid <= 1'b1;
         end
      end
   end

   assert_word_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);
endmodule

// File: rtl/octddr_master.sv
module octddr_master
   import octddr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DQ_W   = 8,
   parameter int LAT_W  = 4,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  cfg_latency,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_read,
   input  logic              req_reg,
   input  logic              req_linear,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   input  logic [LEN_W-1:0]  req_words_m1,
   input  logic              rd_cut,
   output logic              rd_valid,
   output logic [15:0]       rd_data,
   output logic              done,
   output logic              bus_cs_n,
   output logic              bus_ck,
   output logic              bus_ck_n,
   output logic [DQ_W-1:0]   bus_dq_o,
   output logic              bus_dq_oe,
   input  logic [DQ_W-1:0]   bus_dq_i,
   input  logic              bus_strobe
);
   localparam int CNT_W   = ((LEN_W > LAT_W) ? LEN_W : LAT_W) + 1;
   localparam int SH_W    = CA_W + WORD_W;
   localparam int CA_LAST = CA_W / DQ_W - 1;

   generate
      if (ADDR_W != 32) begin : g_bad_addr
         $error("ADDR_W must be 32");
      end
      if (DQ_W * 2 != WORD_W) begin : g_bad_dq
         $error("DQ_W must be half the word width");
      end
      if (LAT_W < 2 || LEN_W < 2) begin : g_bad_cnt
         $error("LAT_W and LEN_W must be at least 2");
      end
   endgenerate

   seq_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic             is_rd;
   logic [LAT_W-1:0] lat_q;
   logic [LEN_W-1:0] wm1_q;
   logic             accept;
   logic [DQ_W-1:0]  tx_byte;
   logic             rd_word_v;
   logic [15:0]      rd_word;

   assign accept    = (st == ST_IDLE) && req_valid;
   assign req_ready = (st == ST_IDLE);
   assign bus_cs_n  = (st == ST_IDLE);
   assign bus_dq_oe = (st == ST_CA) || ((st == ST_DATA) && !is_rd);
   assign bus_dq_o  = bus_dq_oe ? tx_byte : '0;
   assign rd_valid  = rd_word_v;
   assign rd_data   = rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         is_rd <= 1'b0;
         lat_q <= '0;
         wm1_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (accept) begin
               st    <= ST_CA;
               cnt   <= CNT_W'(CA_LAST);
               is_rd <= req_read;
               lat_q <= cfg_latency;
               wm1_q <= req_words_m1;
            end
            ST_CA: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else if (lat_q == '0) begin
                  st  <= ST_DATA;
                  cnt <= is_rd ? CNT_W'({wm1_q, 1'b1}) : CNT_W'(1);
               end else begin
                  st  <= ST_LAT;
                  cnt <= CNT_W'({lat_q, 1'b0}) - CNT_W'(1);
               end
            end
            ST_LAT: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else begin
                  st  <= ST_DATA;
                  cnt <= is_rd ? CNT_W'({wm1_q, 1'b1}) : CNT_W'(1);
               end
            end
            default: begin
               if (cnt == '0 || (is_rd && rd_cut && !cnt[0])) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
         endcase
      end
   end

   octddr_ck_gen u_ck (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st != ST_IDLE),
      .ck   (bus_ck),
      .ck_n (bus_ck_n)
   );

   octddr_tx_shift #(.DQ_W(DQ_W), .SH_W(SH_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .load_val({pack_ca(req_read, req_reg, req_linear, req_addr), req_wdata}),
      .shift   ((st == ST_CA) || ((st == ST_DATA) && !is_rd)),
      .byte_o  (tx_byte)
   );

   octddr_rd_cap #(.DQ_W(DQ_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       ((st == ST_DATA) && is_rd),
      .strobe    (bus_strobe),
      .dq_i      (bus_dq_i),
      .word_valid(rd_word_v),
      .word_o    (rd_word)
   );

   assert_cs_start_ck_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cs_n) |-> !$past(bus_ck));
   assert_cs_end_ck_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |-> !bus_ck);
   assert_done_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bus_cs_n);
   assert_rdv_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> is_rd);
endmodule

// File: tb/octddr_master_tb.sv
module octddr_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_latency = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_read = 1'b0, req_reg = 1'b0, req_linear = 1'b0;
   logic [31:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [3:0]  req_words_m1 = '0;
   logic        rd_cut = 1'b0;
   logic        rd_valid, done;
   logic [15:0] rd_data;
   logic        bus_cs_n, bus_ck, bus_ck_n, bus_dq_oe;
   logic [7:0]  bus_dq_o;
   logic [7:0]  bus_dq_i = '0;
   logic        bus_strobe = 1'b0;

   int total = 0, bad = 0;

   always #5 clk = ~clk;

   octddr_master u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency),
      .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
      .req_reg(req_reg), .req_linear(req_linear), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_words_m1(req_words_m1), .rd_cut(rd_cut),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
      .bus_cs_n(bus_cs_n), .bus_ck(bus_ck), .bus_ck_n(bus_ck_n),
      .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i),
      .bus_strobe(bus_strobe)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input logic [31:0] a, input int j);
      return (a[15:0] + 16'(j) * 16'h0101) ^ 16'h5A3C;
   endfunction

   // Bus-side memory model
   int          edge_n = 0;
   logic [7:0]  cap [0:31];
   logic        oe_log [0:31];
   int          ckn_bad = 0;
   int          cur_lat = 0;
   logic [31:0] cur_addr = '0;

   always @(negedge bus_cs_n) edge_n = 0;
   always @(posedge bus_cs_n) begin
      bus_dq_i   = '0;
      bus_strobe = 1'b0;
   end
   always @(bus_ck) begin
      if (rst_n && !bus_cs_n) begin
         if (bus_ck_n === bus_ck) ckn_bad++;
         if (edge_n < 32) begin
            cap[edge_n]    = bus_dq_o;
            oe_log[edge_n] = bus_dq_oe;
         end
         if (cap[0][7] && edge_n >= 6 + 2 * cur_lat) begin
            automatic int k = edge_n - 6 - 2 * cur_lat;
            automatic logic [15:0] w = pat(cur_addr, k / 2);
            if (k % 2 == 0) begin
               bus_dq_i = w[15:8]; bus_strobe = 1'b1;
            end else begin
               bus_dq_i = w[7:0];  bus_strobe = 1'b0;
            end
         end
         edge_n++;
      end
   end

   // Host-side monitor, sampled away from both clock edges
   logic [15:0] got [0:15];
   int ngot = 0, ndone = 0, done_cs_bad = 0;
   always @(posedge clk) begin
      #2;
      if (rd_valid && ngot < 16) begin
         got[ngot] = rd_data;
         ngot++;
      end
      if (done) begin
         ndone++;
         if (!bus_cs_n) done_cs_bad++;
      end
   end

   task automatic run_txn(input bit rd, input bit rg, input bit lin,
                          input logic [31:0] a, input logic [15:0] wd,
                          input int wm1, input int lat, input bit cut);
      int words, exp_edges, base, waited;
      logic [47:0] exp_ca, got_ca;
      bit oe_ok;
      @(negedge clk);
      req_read = rd; req_reg = rg; req_linear = lin; req_addr = a;
      req_wdata = wd; req_words_m1 = 4'(wm1); cfg_latency = 4'(lat);
      rd_cut = cut; req_valid = 1'b1;
      cur_lat = lat; cur_addr = a; ngot = 0; ndone = 0; done_cs_bad = 0;
      ckn_bad = 0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9 ready low while busy", 64'(req_ready), 64'd0);
      // later changes must not affect this transaction (R9)
      req_addr = ~a; req_wdata = ~wd; req_read = ~rd; cfg_latency = 4'd7;
      req_words_m1 = 4'(wm1 + 3);
      waited = 0;
      while (ndone == 0 && waited < 200) begin
         @(negedge clk);
         waited++;
      end
      repeat (2) @(negedge clk);

      words = rd ? (cut ? 1 : wm1 + 1) : 1;
      exp_edges = 6 + 2 * lat + 2 * words;
      chk(edge_n == exp_edges, "R4/R5/R6/R7 bus edge count", 64'(edge_n), 64'(exp_edges));

      exp_ca = {rd, rg, lin, a[31:3], 13'd0, a[2:0]};
      got_ca = {cap[0], cap[1], cap[2], cap[3], cap[4], cap[5]};
      chk(got_ca == exp_ca, "R2/R3 command/address", 64'(got_ca), 64'(exp_ca));
      oe_ok = 1'b1;
      for (int i = 0; i < 6; i++) if (!oe_log[i]) oe_ok = 1'b0;
      chk(oe_ok, "R2 enable during command", 64'(oe_ok), 64'd1);
      oe_ok = 1'b1;
      for (int i = 6; i < 6 + 2 * lat; i++) if (oe_log[i]) oe_ok = 1'b0;
      chk(oe_ok, "R4 released in latency", 64'(oe_ok), 64'd1);

      base = 6 + 2 * lat;
      if (!rd) begin
         chk({cap[base], cap[base+1]} == wd, "R5 write word bytes",
             64'({cap[base], cap[base+1]}), 64'(wd));
         chk(oe_log[base] && oe_log[base+1], "R5 enable on write data",
             64'({oe_log[base], oe_log[base+1]}), 64'd3);
         chk(ngot == 0, "R6 no read words on write", 64'(ngot), 64'd0);
      end else begin
         chk(ngot == words, "R6/R7 read word count", 64'(ngot), 64'(words));
         for (int j = 0; j < words && j < ngot; j++)
            chk(got[j] == pat(a, j), "R6 read word value", 64'(got[j]), 64'(pat(a, j)));
      end
      chk(ndone == 1 && done_cs_bad == 0, "R8 single done with cs high",
          64'(ndone), 64'd1);
      chk(ckn_bad == 0, "R11 complement clock", 64'(ckn_bad), 64'd0);
      chk(bus_cs_n && !bus_ck && bus_ck_n, "R1 idle clock low",
          64'({bus_cs_n, bus_ck}), 64'd2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_cs_n && !bus_ck && bus_ck_n && !bus_dq_oe && req_ready && !done && !rd_valid,
          "R10 reset state",
          64'({bus_cs_n, bus_ck, bus_ck_n, bus_dq_oe, req_ready, done, rd_valid}),
          64'b1010100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int lat = 0; lat < 4; lat++)
         for (int wm = 0; wm < 4; wm++)
            run_txn(1'b1, 1'(wm & 1), 1'(lat & 1), 32'h1234_5678 + 32'(lat * 37 + wm * 5),
                    16'h0, wm, lat, 1'b0);
      for (int lat = 0; lat < 4; lat++)
         for (int lin = 0; lin < 2; lin++)
            run_txn(1'b0, 1'(lin), 1'(lin), 32'hCAFE_0003 ^ 32'(lat << 9),
                    16'hB7E1 + 16'(lat * 3 + lin), 3, lat, 1'(lin));
      run_txn(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 16'h0, 3, 2, 1'b1);
      run_txn(1'b1, 1'b1, 1'b0, 32'h0000_0000, 16'h0, 2, 0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule